// File: doc/BRIEF.md
# Slave-Mode and Quadrature Encoder Controller

This block sits beside a timer time base and decides when and how its counter moves. It watches one trigger input and a pair of quadrature channels. In the slave modes it turns trigger edges or trigger levels into count, restart and start controls. In the encoder modes it decodes the two channels into single-step counts with a direction. The counter itself, input filtering and trigger source selection are outside the block.

All three inputs pass through a synchronizer before any edge is detected. The trigger path can invert the trigger and can divide its active edges by 1, 2, 4 or 8. Each quadrature channel has its own inversion. The block has one controlling state machine with five states:
- `ST_OFF` is entered when the mode code is 0.
- `ST_PASSIVE` serves the restart, gated and external-clock modes.
- `ST_ARMED` is the trigger-start mode waiting for its first edge. It moves to `ST_RUNNING` on an active edge.
- `ST_RUNNING` is the trigger-start mode after that edge. It stays there until the mode changes.
- `ST_ENCODE` serves all three encoder modes.

The state machine leaves whatever state it is in for the state the new mode code selects on the next clock edge. Leaving trigger-start mode and returning re-arms it.

Top module: `slave_enc_ctrl`

## Requirements
- R1: Mode code 0 (off): `cnt_en`, `cnt_reset`, `cnt_start` and `trig_evt` stay low whatever the inputs do. The mode codes are 0 off, 1 encoder on channel A, 2 encoder on channel B, 3 encoder on both channels, 4 restart, 5 gated, 6 trigger-start and 7 external clock.
- R2: A change on any input first affects the outputs in the cycle that follows the second rising clock edge after the change. This is the synchronizer latency with the default parameters.
- R3: Restart mode (code 4): `cnt_en` is held high. Each active trigger edge gives a one-cycle `cnt_reset` pulse and a one-cycle `trig_evt` pulse. An inactive edge gives neither.
- R4: Gated mode (code 5): `cnt_en` follows the synchronized active trigger level, `cnt_dir` is 0, and an active edge pulses `trig_evt`.
- R5: Trigger-start mode (code 6): the first active edge gives a one-cycle `cnt_start` pulse, and `cnt_en` is high from the next cycle on. Later edges give `trig_evt` but no further `cnt_start`. Leaving the mode and re-entering it re-arms the mode with `cnt_en` low.
- R6: External-clock mode (code 7): each active trigger edge gives exactly one cycle of `cnt_en`, together with `trig_evt`.
- R7: With `trg_invert`=1, falling trigger edges are active and rising ones are not. In gated mode a low trigger enables counting.
- R8: `trg_psc` code p passes only every 2^p-th active trigger edge. Edges are counted from reset. `cnt_en` and `trig_evt` react only to the passed edges.
- R9: Encoder mode 1 steps (`cnt_en` for one cycle) on each channel A edge. `cnt_dir`=1 (down) when A equals B after the edge. Between steps `cnt_dir` holds the last direction.
- R10: Encoder mode 2 steps only on channel B edges, counting down when A differs from B after the edge.
- R11: Encoder mode 3 steps on edges of both channels, each edge using the rule of R9 or R10. A leading B counts up and B leading A counts down.
- R12: In the encoder modes, a cycle in which both channels change at once gives no step.
- R13: `ch_invert[0]` inverts channel A and `ch_invert[1]` inverts channel B before decoding. Either one reverses the direction of the same physical sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Mode code (see R1) |
| trg_in | input | 1 | Selected trigger input, asynchronous |
| trg_invert | input | 1 | 1 makes falling trigger edges and the low level active |
| trg_psc | input | PSC_W (2) | Trigger edge divider code: divides by 2^code |
| ch_a | input | 1 | Quadrature channel A, asynchronous |
| ch_b | input | 1 | Quadrature channel B, asynchronous |
| ch_invert | input | 2 | Per-channel inversion: bit 0 for A, bit 1 for B |
| cnt_en | output | 1 | Counter advances in this cycle |
| cnt_dir | output | 1 | Count direction: 0 up, 1 down |
| cnt_reset | output | 1 | One-cycle counter re-initialize and register update request |
| cnt_start | output | 1 | One-cycle counter start request |
| trig_evt | output | 1 | One-cycle flag for an accepted trigger edge in a slave mode |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer and a two-bit divider code. The two-stage synchronizer fixes the latency of R2, so every check samples in the one cycle where a pulse must be seen, and again in the cycle after it. The two-bit divider code brings divide-by-2 and divide-by-4 sequences within reach in a few dozen cycles. It also lets the bench confirm the edge count carried over from earlier tests. The encoder tests walk forward and reverse quadrature sequences, a double change and an inverted channel through all three decoding modes.

// File: rtl/sec_pkg.sv
package sec_pkg;

    typedef enum logic [2:0] {
        MODE_OFF     = 3'd0,
        MODE_QA      = 3'd1,
        MODE_QB      = 3'd2,
        MODE_QAB     = 3'd3,
        MODE_RESTART = 3'd4,
        MODE_GATE    = 3'd5,
        MODE_START   = 3'd6,
        MODE_EXTCLK  = 3'd7
    } sec_mode_e;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_PASSIVE,
        ST_ARMED,
        ST_RUNNING,
        ST_ENCODE
    } sec_state_e;

endpackage

// File: rtl/sec_sync.sv
module sec_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prev
);
    // STAGES flops of synchronizer plus one flop kept for edge detection
    logic [WIDTH-1:0] pipe [STAGES+1];

    for (genvar g = 0; g <= STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= '0;
                else        pipe[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= '0;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    assign cur  = pipe[STAGES-1];
    assign prev = pipe[STAGES];
endmodule

// File: rtl/sec_trig_path.sv
module sec_trig_path #(
    parameter int PSC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl_cur,
    input  logic             lvl_prev,
    input  logic             invert,
    input  logic [PSC_W-1:0] psc,
    output logic             lvl,
    output logic             rise_div
);
    localparam int CNT_W = (1 << PSC_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             rise_raw;
    logic             pass;

    assign lvl      = lvl_cur ^ invert;
    assign rise_raw = lvl & ~(lvl_prev ^ invert);
    assign limit    = CNT_W'((32'd1 << psc) - 32'd1);
    // ">=" recovers at once if the code is lowered mid-count
    assign pass     = (cnt_q >= limit);
    assign rise_div = rise_raw & pass;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (rise_raw) cnt_q <= pass ? '0 : cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/sec_quad.sv
module sec_quad (
    input  logic       a_cur,
    input  logic       a_prev,
    input  logic       b_cur,
    input  logic       b_prev,
    input  logic [1:0] inv,
    input  logic       use_a,
    input  logic       use_b,
    output logic       step,
    output logic       down
);
    logic a, pa, b, pb, ea, eb;

    assign a  = a_cur  ^ inv[0];
    assign pa = a_prev ^ inv[0];
    assign b  = b_cur  ^ inv[1];
    assign pb = b_prev ^ inv[1];
    assign ea = a ^ pa;
    assign eb = b ^ pb;

    // a double change carries no direction information and is dropped
    assign step = ~(ea & eb) & ((ea & use_a) | (eb & use_b));
    assign down = ea ? (a == b) : (a != b);
endmodule

// File: rtl/slave_enc_ctrl.sv
module slave_enc_ctrl
    import sec_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PSC_W       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_sel,
    input  logic             trg_in,
    input  logic             trg_invert,
    input  logic [PSC_W-1:0] trg_psc,
    input  logic             ch_a,
    input  logic             ch_b,
    input  logic [1:0]       ch_invert,
    output logic             cnt_en,
    output logic             cnt_dir,
    output logic             cnt_reset,
    output logic             cnt_start,
    output logic             trig_evt
);
    sec_mode_e  mode;
    sec_state_e st_q, st_d;
    logic [2:0] s_cur, s_prev;
    logic       t_lvl, t_rise;
    logic       q_step, q_down, dir_q;
    logic       use_a, use_b;

    assign mode  = sec_mode_e'(mode_sel);
    assign use_a = (mode == MODE_QA) || (mode == MODE_QAB);
    assign use_b = (mode == MODE_QB) || (mode == MODE_QAB);

    sec_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
        .clk (clk), .rst_n (rst_n),
        .din ({trg_in, ch_b, ch_a}),
        .cur (s_cur), .prev (s_prev)
    );

    sec_trig_path #(.PSC_W(PSC_W)) trig_i (
        .clk (clk), .rst_n (rst_n),
        .lvl_cur (s_cur[2]), .lvl_prev (s_prev[2]),
        .invert (trg_invert), .psc (trg_psc),
        .lvl (t_lvl), .rise_div (t_rise)
    );

    sec_quad quad_i (
        .a_cur (s_cur[0]), .a_prev (s_prev[0]),
        .b_cur (s_cur[1]), .b_prev (s_prev[1]),
        .inv (ch_invert), .use_a (use_a), .use_b (use_b),
        .step (q_step), .down (q_down)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (mode)
            MODE_OFF:                   st_d = ST_OFF;
            MODE_QA, MODE_QB, MODE_QAB: st_d = ST_ENCODE;
            MODE_START: begin
                if (st_q == ST_ARMED)        st_d = t_rise ? ST_RUNNING : ST_ARMED;
                else if (st_q != ST_RUNNING) st_d = ST_ARMED;
            end
            default:                    st_d = ST_PASSIVE;
        endcase
    end

    // held encoder direction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   dir_q <= 1'b0;
        else if (st_q != ST_ENCODE)   dir_q <= 1'b0;
        else if (q_step)              dir_q <= q_down;
    end

    // outputs
    always_comb begin
        cnt_en    = 1'b0;
        cnt_reset = 1'b0;
        cnt_start = 1'b0;
        trig_evt  = 1'b0;
        cnt_dir   = (st_q == ST_ENCODE && q_step) ? q_down : dir_q;
        unique case (st_q)
            ST_OFF: ;
            ST_PASSIVE: begin
                trig_evt = t_rise;
                if (mode == MODE_RESTART) begin
                    cnt_en    = 1'b1;
                    cnt_reset = t_rise;
                end else if (mode == MODE_GATE) begin
                    cnt_en = t_lvl;
                end else if (mode == MODE_EXTCLK) begin
                    cnt_en = t_rise;
                end
            end
            ST_ARMED: begin
                trig_evt  = t_rise;
                cnt_start = t_rise && (mode == MODE_START);
            end
            ST_RUNNING: begin
                cnt_en   = 1'b1;
                trig_evt = t_rise;
            end
            ST_ENCODE: cnt_en = q_step;
            default: ;
        endcase
    end

    assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF && $stable(mode_sel)) |-> !(cnt_en || cnt_reset || cnt_start || trig_evt));

    assert_reset_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_reset |=> !cnt_reset);

    assert_restart_start_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cnt_reset, cnt_start}));

    assert_start_runs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_start && mode == MODE_START) |=> (cnt_en || mode != MODE_START));

    assert_start_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_start |=> !cnt_start);

    assert_ext_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && st_q == ST_PASSIVE && mode == MODE_EXTCLK) |=> (!cnt_en || !$stable(mode_sel)));

    assert_enc_no_trig_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ENCODE) |-> !(trig_evt || cnt_reset || cnt_start));

    assert_double_change_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ENCODE && s_cur[0] != s_prev[0] && s_cur[1] != s_prev[1]) |-> !cnt_en);
endmodule

// File: tb/slave_enc_ctrl_tb_top.sv
`timescale 1ns/1ps
module slave_enc_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] mode_sel;
    logic       trg_in, trg_invert;
    logic [1:0] trg_psc;
    logic       ch_a, ch_b;
    logic [1:0] ch_invert;
    logic       cnt_en, cnt_dir, cnt_reset, cnt_start, trig_evt;

    int  n_checks = 0;
    int  n_bad    = 0;
    bit  done     = 1'b0;

    always #2.5 clk = ~clk;

    slave_enc_ctrl dut_i (
        .clk (clk), .rst_n (rst_n), .mode_sel (mode_sel),
        .trg_in (trg_in), .trg_invert (trg_invert), .trg_psc (trg_psc),
        .ch_a (ch_a), .ch_b (ch_b), .ch_invert (ch_invert),
        .cnt_en (cnt_en), .cnt_dir (cnt_dir), .cnt_reset (cnt_reset),
        .cnt_start (cnt_start), .trig_evt (trig_evt)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge where the change is visible
    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drv_trg(logic v);
        trg_in = v;
        settle();
    endtask

    task automatic drv_ab(logic a, logic b);
        ch_a = a;
        ch_b = b;
        settle();
    endtask

    task automatic set_mode(logic [2:0] m);
        mode_sel = m;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk("R1", "en after reset", int'(cnt_en), 0);
        chk("R1", "evt after reset", int'(trig_evt), 0);
        drv_trg(1'b1);
        chk("R1", "evt when off", int'(trig_evt), 0);
        chk("R1", "reset when off", int'(cnt_reset), 0);
        drv_ab(1'b1, 1'b0);
        chk("R1", "en when off", int'(cnt_en), 0);
        drv_ab(1'b0, 1'b0);
        drv_trg(1'b0);
    endtask

    task automatic t_restart();
        set_mode(3'd4);
        chk("R3", "en held", int'(cnt_en), 1);
        trg_in = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R2", "no reset after one edge", int'(cnt_reset), 0);
        @(posedge clk); @(negedge clk);
        chk("R2", "reset after two edges", int'(cnt_reset), 1);
        chk("R3", "evt with reset", int'(trig_evt), 1);
        @(negedge clk);
        chk("R3", "reset one cycle", int'(cnt_reset), 0);
        drv_trg(1'b0);
        chk("R3", "no reset on fall", int'(cnt_reset), 0);
        chk("R3", "en still held", int'(cnt_en), 1);
    endtask

    task automatic t_gated();
        set_mode(3'd5);
        chk("R4", "en low level", int'(cnt_en), 0);
        drv_trg(1'b1);
        chk("R4", "en high level", int'(cnt_en), 1);
        chk("R4", "evt on edge", int'(trig_evt), 1);
        chk("R4", "dir up", int'(cnt_dir), 0);
        @(negedge clk);
        chk("R4", "en stays", int'(cnt_en), 1);
        drv_trg(1'b0);
        chk("R4", "en drops", int'(cnt_en), 0);
    endtask

    task automatic t_trigger();
        set_mode(3'd6);
        chk("R5", "armed en", int'(cnt_en), 0);
        drv_trg(1'b1);
        chk("R5", "start pulse", int'(cnt_start), 1);
        chk("R5", "evt pulse", int'(trig_evt), 1);
        @(negedge clk);
        chk("R5", "start one cycle", int'(cnt_start), 0);
        chk("R5", "running en", int'(cnt_en), 1);
        drv_trg(1'b0);
        drv_trg(1'b1);
        chk("R5", "no second start", int'(cnt_start), 0);
        chk("R5", "later evt", int'(trig_evt), 1);
        drv_trg(1'b0);
        set_mode(3'd0);
        set_mode(3'd6);
        chk("R5", "re-armed en", int'(cnt_en), 0);
        drv_trg(1'b1);
        chk("R5", "start after re-arm", int'(cnt_start), 1);
        drv_trg(1'b0);
    endtask

    task automatic t_extclk();
        set_mode(3'd7);
        drv_trg(1'b1);
        chk("R6", "tick", int'(cnt_en), 1);
        chk("R6", "tick evt", int'(trig_evt), 1);
        @(negedge clk);
        chk("R6", "tick one cycle", int'(cnt_en), 0);
        drv_trg(1'b0);
        chk("R6", "no tick on fall", int'(cnt_en), 0);
    endtask

    task automatic t_invert();
        trg_invert = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7", "no tick on invert switch", int'(cnt_en), 0);
        drv_trg(1'b1);
        chk("R7", "no tick on rise", int'(cnt_en), 0);
        drv_trg(1'b0);
        chk("R7", "tick on fall", int'(cnt_en), 1);
        set_mode(3'd5);
        chk("R7", "gated active low", int'(cnt_en), 1);
        trg_invert = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7", "gated restored", int'(cnt_en), 0);
    endtask

    task automatic t_prescale();
        set_mode(3'd7);
        trg_psc = 2'd2;
        for (int i = 0; i < 4; i++) begin
            drv_trg(1'b1);
            chk("R8", "div4 tick", int'(cnt_en), (i == 3) ? 1 : 0);
            chk("R8", "div4 evt", int'(trig_evt), (i == 3) ? 1 : 0);
            drv_trg(1'b0);
        end
        trg_psc = 2'd1;
        for (int i = 0; i < 2; i++) begin
            drv_trg(1'b1);
            chk("R8", "div2 tick", int'(cnt_en), (i == 1) ? 1 : 0);
            drv_trg(1'b0);
        end
        trg_psc = 2'd0;
    endtask

    task automatic t_enc_a();
        set_mode(3'd1);
        drv_ab(1'b1, 1'b0);
        chk("R9", "A rise step", int'(cnt_en), 1);
        chk("R9", "A rise up", int'(cnt_dir), 0);
        drv_ab(1'b1, 1'b1);
        chk("R9", "B edge ignored", int'(cnt_en), 0);
        drv_ab(1'b0, 1'b1);
        chk("R9", "A fall up", int'(cnt_dir), 0);
        chk("R9", "A fall step", int'(cnt_en), 1);
        drv_ab(1'b1, 1'b1);
        chk("R9", "reverse A step", int'(cnt_en), 1);
        chk("R9", "reverse down", int'(cnt_dir), 1);
        @(negedge clk);
        chk("R9", "dir held", int'(cnt_dir), 1);
        chk("R9", "step one cycle", int'(cnt_en), 0);
        drv_ab(1'b1, 1'b0);
        drv_ab(1'b0, 1'b0);
        chk("R9", "down again", int'(cnt_dir), 1);
    endtask

    task automatic t_enc_b();
        set_mode(3'd2);
        drv_ab(1'b1, 1'b0);
        chk("R10", "A edge ignored", int'(cnt_en), 0);
        drv_ab(1'b1, 1'b1);
        chk("R10", "B step", int'(cnt_en), 1);
        chk("R10", "B up", int'(cnt_dir), 0);
        drv_ab(1'b0, 1'b1);
        drv_ab(1'b0, 1'b0);
        chk("R10", "B fall up", int'(cnt_dir), 0);
        drv_ab(1'b0, 1'b1);
        chk("R10", "B lead step", int'(cnt_en), 1);
        chk("R10", "B lead down", int'(cnt_dir), 1);
        drv_ab(1'b0, 1'b0);
    endtask

    task automatic t_enc_ab();
        set_mode(3'd3);
        drv_ab(1'b1, 1'b0);
        chk("R11", "A step", int'(cnt_en), 1);
        chk("R11", "A up", int'(cnt_dir), 0);
        drv_ab(1'b1, 1'b1);
        chk("R11", "B step", int'(cnt_en), 1);
        chk("R11", "B up", int'(cnt_dir), 0);
        drv_ab(1'b0, 1'b0);
        chk("R12", "double change no step", int'(cnt_en), 0);
        chk("R12", "dir kept", int'(cnt_dir), 0);
        drv_ab(1'b0, 1'b1);
        chk("R11", "B lead down", int'(cnt_dir), 1);
        chk("R11", "B lead step", int'(cnt_en), 1);
        drv_ab(1'b0, 1'b0);
        chk("R11", "return up", int'(cnt_dir), 0);
    endtask

    task automatic t_enc_invert();
        ch_invert = 2'b01;
        repeat (3) @(negedge clk);
        chk("R13", "no step on invert switch", int'(cnt_en), 0);
        drv_ab(1'b0, 1'b1);
        chk("R13", "inverted step", int'(cnt_en), 1);
        chk("R13", "inverted dir up", int'(cnt_dir), 0);
        ch_invert = 2'b00;
        drv_ab(1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        mode_sel = 3'd0;
        trg_in = 1'b0;
        trg_invert = 1'b0;
        trg_psc = 2'd0;
        ch_a = 1'b0;
        ch_b = 1'b0;
        ch_invert = 2'b00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_restart();
        t_gated();
        t_trigger();
        t_extclk();
        t_invert();
        t_prescale();
        t_enc_a();
        t_enc_b();
        t_enc_ab();
        t_enc_invert();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule